// File: doc/BRIEF.md
# Clock Output Stop and Enable Gating

This block sits between the clock synthesis stage of a clock generator and its output pads. It receives the already-generated CPU, PCI, SDRAM, reference, 48 MHz, 24 MHz and test clocks. It produces the gated output clocks for the following groups:

- a CPU pair
- six stoppable PCI clocks and one free-running PCI clock
- eight SDRAM clocks
- three reference clocks
- two selectable 48/24 MHz clocks

Each output has its own enable bit from the configuration registers. A global function field selects normal operation, test-clock substitution or a quiet high-impedance state.

A strap input decides what two shared pins do. With the strap high, both pins are the upper two SDRAM clock outputs. With the strap low, they stop being driven and become active-low stop inputs: one for the CPU pair and one for the stoppable PCI clocks. Every gating decision is synchronised into the clock domain it controls. It takes effect only while that clock is low, so an output never shows a shortened high pulse.

Top module: `clkgate_top`

## Requirements
- R1: The shared pins follow the strap. With `mode_strap`=1, `shared_oe`=2'b11, `shared_out[0]` carries SDRAM clock 7 and `shared_out[1]` carries SDRAM clock 6. With `mode_strap`=0, `shared_oe`=2'b00 and both `shared_out` bits stay low, while `shared_in[0]` is the PCI stop and `shared_in[1]` is the CPU stop (both active low).
- R2: With `mode_strap`=0 and `shared_in[1]`=0, both `cpu_out` bits settle to a constant 0. They resume following their source once the pin returns high.
- R3: With `mode_strap`=0 and `shared_in[0]`=0, all six `pci_out` bits settle to a constant 0, while `pci_free_out` keeps toggling.
- R4: With `mode_strap`=1 the values on `shared_in` have no effect on any output.
- R5: An enable bit of 1 lets its output follow its source clock. An enable bit of 0 holds that output low, with `drive_en` still 1.
- R6: For each 48/24 output `i`, `fx_sel[i]`=1 selects the 48 MHz source and 0 selects the 24 MHz source.
- R7: `func_sel`=2'b11 is the quiet state: `drive_en`=0, `shared_oe`=2'b00 and every clock output settles low. Codes 2'b00 and 2'b10 are normal operation.
- R8: `func_sel`=2'b01 is test mode. The CPU, SDRAM and shared outputs carry the test clock divided by 2. Both PCI outputs carry it divided by 4. A 48/24 output carries it divided by 2 when selecting 48 and divided by 4 when selecting 24. The reference outputs carry the undivided test clock.
- R9: Gating changes take effect only while the source is low, so every high pulse of a gated output lasts a full source high phase.
- R10: While `rst_n`=0 every clock output is low. After release, with all enables 1, both selects 1, `func_sel`=2'b00 and `mode_strap`=1, every clock output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_in | input | 1 | CPU source clock |
| pci_clk_in | input | 1 | PCI source clock |
| sdram_clk_in | input | 1 | SDRAM source clock |
| ref_clk_in | input | 1 | Reference source clock |
| clk48_in | input | 1 | 48 MHz source clock |
| clk24_in | input | 1 | 24 MHz source clock |
| test_clk_in | input | 1 | Test clock for substitution |
| mode_strap | input | 1 | 1: shared pins are SDRAM outputs; 0: shared pins are stop inputs |
| func_sel | input | 2 | 00/10 normal, 01 test, 11 quiet |
| cpu_en | input | 2 | Per-output CPU enables |
| pci_en | input | 6 | Per-output stoppable PCI enables |
| pci_free_en | input | 1 | Free-running PCI enable |
| sdram_en | input | 8 | Per-output SDRAM enables (6 and 7 reach the shared pins) |
| ref_en | input | 3 | Per-output reference enables |
| fx_en | input | 2 | 48/24 output enables |
| fx_sel | input | 2 | 48/24 selects, 1 = 48 |
| shared_in | input | 2 | Shared pin input values |
| cpu_out | output | 2 | Gated CPU clocks |
| pci_out | output | 6 | Gated stoppable PCI clocks |
| pci_free_out | output | 1 | Gated free-running PCI clock |
| sdram_out | output | 6 | Gated dedicated SDRAM clocks 0..5 |
| shared_out | output | 2 | Shared pin output values |
| shared_oe | output | 2 | Shared pin drive enables |
| ref_out | output | 3 | Gated reference clocks |
| fx_out | output | 2 | Gated 48/24 clocks |
| drive_en | output | 1 | Global output drive enable, 0 in quiet state |

## Verification
The assertions assume that every source clock is free-running and that control inputs are quasi-static compared with the clock they gate. A stop, enable or strap value must therefore be held for at least four edges of the affected source before the output is judged. The function field is assumed to change only between phases of operation. The bench holds to this by driving controls only at instants halfway between source edges and waiting many reference periods after each change before comparing. In the pulse-width phase the PCI stop pin is toggled at random intervals, but only the completed high pulses are measured.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    FUNC_RUN  = 2'b00,
    FUNC_TEST = 2'b01,
    FUNC_ALT  = 2'b10,
    FUNC_HIZ  = 2'b11
  } func_e;

  localparam int unsigned SHARED_PINS = 2;
endpackage

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_out
);
  logic [1:0] rst_pipe_q;
  logic       cell_rst_n;
  logic [1:0] req_pipe_q, req_pipe_d;
  logic [1:0] age_q, age_d;
  logic       gate_q, gate_d;

  // reset release aligned to this domain
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign cell_rst_n = rst_pipe_q[1];

  always_comb begin
    req_pipe_d = {req_pipe_q[0], run_req};
    age_d      = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    gate_d     = req_pipe_q[1];
  end

  always_ff @(posedge src_clk or negedge cell_rst_n) begin
    if (!cell_rst_n) begin
      req_pipe_q <= 2'b00;
      age_q      <= 2'd0;
    end else begin
      req_pipe_q <= req_pipe_d;
      age_q      <= age_d;
    end
  end

  // gate updates only at the falling edge: output is low when it moves
  always_ff @(negedge src_clk or negedge cell_rst_n) begin
    if (!cell_rst_n) gate_q <= 1'b0;
    else             gate_q <= gate_d;
  end

  assign clk_out = src_clk & gate_q;

  assert_idle_low_R2: assert property (@(posedge src_clk) disable iff (!cell_rst_n)
    (!run_req && $past(!run_req) && $past(!run_req, 2) && $past(!run_req, 3)) |-> !gate_q)
    else $error("gate still open after stop request");

  assert_resume_R5: assert property (@(posedge src_clk) disable iff (!cell_rst_n)
    (age_q == 2'd3 && run_req && $past(run_req) && $past(run_req, 2) && $past(run_req, 3)) |-> gate_q)
    else $error("gate not reopened after run request");
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] run_req,
  output logic [WIDTH-1:0] clk_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    clkgate_cell u_cell (
      .src_clk (src_clk),
      .rst_n   (rst_n),
      .run_req (run_req[g]),
      .clk_out (clk_out[g])
    );
  end
endmodule

// File: rtl/clkgate_tdiv.sv
module clkgate_tdiv (
  input  logic tclk,
  input  logic rst_n,
  output logic div1,
  output logic div2,
  output logic div4
);
  logic [1:0] rst_pipe_q;
  logic       div_rst_n;
  logic       d2_q, d2_d, d4_q, d4_d;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign div_rst_n = rst_pipe_q[1];

  always_comb begin
    d2_d = ~d2_q;
    d4_d = d2_q ? ~d4_q : d4_q;
  end

  always_ff @(posedge tclk or negedge div_rst_n) begin
    if (!div_rst_n) begin
      d2_q <= 1'b0;
      d4_q <= 1'b0;
    end else begin
      d2_q <= d2_d;
      d4_q <= d4_d;
    end
  end

  assign div1 = tclk;
  assign div2 = d2_q;
  assign div4 = d4_q;

  assert_div4_step_R8: assert property (@(posedge tclk) disable iff (!div_rst_n)
    !$past(d2_q) |-> (d4_q == $past(d4_q)))
    else $error("divide-by-4 moved on wrong edge");
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
  import clkgate_pkg::*;
#(
  parameter int unsigned N_CPU   = 2,
  parameter int unsigned N_PCI   = 6,
  parameter int unsigned N_SDRAM = 8,
  parameter int unsigned N_REF   = 3,
  parameter int unsigned N_FX    = 2
) (
  input  logic                       rst_n,
  input  logic                       cpu_clk_in,
  input  logic                       pci_clk_in,
  input  logic                       sdram_clk_in,
  input  logic                       ref_clk_in,
  input  logic                       clk48_in,
  input  logic                       clk24_in,
  input  logic                       test_clk_in,
  input  logic                       mode_strap,
  input  logic [1:0]                 func_sel,
  input  logic [N_CPU-1:0]           cpu_en,
  input  logic [N_PCI-1:0]           pci_en,
  input  logic                       pci_free_en,
  input  logic [N_SDRAM-1:0]         sdram_en,
  input  logic [N_REF-1:0]           ref_en,
  input  logic [N_FX-1:0]            fx_en,
  input  logic [N_FX-1:0]            fx_sel,
  input  logic [1:0]                 shared_in,
  output logic [N_CPU-1:0]           cpu_out,
  output logic [N_PCI-1:0]           pci_out,
  output logic                       pci_free_out,
  output logic [N_SDRAM-3:0]         sdram_out,
  output logic [1:0]                 shared_out,
  output logic [1:0]                 shared_oe,
  output logic [N_REF-1:0]           ref_out,
  output logic [N_FX-1:0]            fx_out,
  output logic                       drive_en
);
  localparam int unsigned N_DED = N_SDRAM - SHARED_PINS;

  func_e func;
  logic  test_on, hiz_on;
  logic  cpu_run_n, pci_run_n;
  logic  t_div1, t_div2, t_div4;
  logic  cpu_src, pci_src, sdram_src, ref_src;
  logic [N_FX-1:0]    fx_src;
  logic [N_CPU-1:0]   cpu_req;
  logic [N_PCI-1:0]   pci_req;
  logic               free_req;
  logic [N_SDRAM-1:0] sdram_req;
  logic [N_REF-1:0]   ref_req;
  logic [N_FX-1:0]    fx_req;
  logic [N_SDRAM-1:0] sdram_gated;

  assign func    = func_e'(func_sel);
  assign test_on = (func == FUNC_TEST);
  assign hiz_on  = (func == FUNC_HIZ);

  // stop pins count only when the strap gives the shared pins to them
  assign cpu_run_n = mode_strap | shared_in[1];
  assign pci_run_n = mode_strap | shared_in[0];

  always_comb begin
    cpu_req  = cpu_en & {N_CPU{cpu_run_n & ~hiz_on}};
    pci_req  = pci_en & {N_PCI{pci_run_n & ~hiz_on}};
    free_req = pci_free_en & ~hiz_on;
    ref_req  = ref_en & {N_REF{~hiz_on}};
    fx_req   = fx_en & {N_FX{~hiz_on}};
    sdram_req = sdram_en & {N_SDRAM{~hiz_on}};
    sdram_req[N_SDRAM-1:N_DED] = sdram_req[N_SDRAM-1:N_DED] & {SHARED_PINS{mode_strap}};
  end

  clkgate_tdiv u_tdiv (
    .tclk  (test_clk_in),
    .rst_n (rst_n),
    .div1  (t_div1),
    .div2  (t_div2),
    .div4  (t_div4)
  );

  always_comb begin
    cpu_src   = test_on ? t_div2 : cpu_clk_in;
    pci_src   = test_on ? t_div4 : pci_clk_in;
    sdram_src = test_on ? t_div2 : sdram_clk_in;
    ref_src   = test_on ? t_div1 : ref_clk_in;
    for (int i = 0; i < int'(N_FX); i++) begin
      if (test_on) fx_src[i] = fx_sel[i] ? t_div2 : t_div4;
      else         fx_src[i] = fx_sel[i] ? clk48_in : clk24_in;
    end
  end

  clkgate_bank #(.WIDTH(N_CPU)) u_cpu (
    .src_clk (cpu_src), .rst_n (rst_n), .run_req (cpu_req), .clk_out (cpu_out));

  clkgate_bank #(.WIDTH(N_PCI)) u_pci (
    .src_clk (pci_src), .rst_n (rst_n), .run_req (pci_req), .clk_out (pci_out));

  clkgate_cell u_pci_free (
    .src_clk (pci_src), .rst_n (rst_n), .run_req (free_req), .clk_out (pci_free_out));

  clkgate_bank #(.WIDTH(N_SDRAM)) u_sdram (
    .src_clk (sdram_src), .rst_n (rst_n), .run_req (sdram_req), .clk_out (sdram_gated));

  clkgate_bank #(.WIDTH(N_REF)) u_ref (
    .src_clk (ref_src), .rst_n (rst_n), .run_req (ref_req), .clk_out (ref_out));

  for (genvar f = 0; f < N_FX; f++) begin : g_fx
    clkgate_cell u_fx (
      .src_clk (fx_src[f]), .rst_n (rst_n), .run_req (fx_req[f]), .clk_out (fx_out[f]));
  end

  assign sdram_out  = sdram_gated[N_DED-1:0];
  assign shared_out = {sdram_gated[N_SDRAM-2], sdram_gated[N_SDRAM-1]};
  assign shared_oe  = {SHARED_PINS{mode_strap & ~hiz_on}};
  assign drive_en   = ~hiz_on;

  logic shared_as_input;
  assign shared_as_input = !mode_strap && (func_sel == 2'b00);

  assert_shared_quiet_R1: assert property (@(negedge sdram_clk_in) disable iff (!rst_n)
    (shared_as_input && $past(shared_as_input) && $past(shared_as_input, 2)
     && $past(shared_as_input, 3)) |-> (shared_out == 2'b00))
    else $error("shared pin output active while strapped as stop input");
endmodule

// File: tb/clkgate_top_bench.sv
`timescale 1ns/100ps
module clkgate_top_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic cpu_s = 0, pci_s = 0, sd_s = 0, ref_s = 0, c48_s = 0, c24_s = 0, t_s = 0;
  logic mode_strap;
  logic [1:0] func_sel;
  logic [1:0] cpu_en;
  logic [5:0] pci_en;
  logic pci_free_en;
  logic [7:0] sdram_en;
  logic [2:0] ref_en;
  logic [1:0] fx_en, fx_sel, shared_in;
  logic [1:0] cpu_out;
  logic [5:0] pci_out;
  logic pci_free_out;
  logic [5:0] sdram_out;
  logic [1:0] shared_out, shared_oe;
  logic [2:0] ref_out;
  logic [1:0] fx_out;
  logic drive_en;

  int checks = 0;
  int fails  = 0;
  int rises [22];

  always #2.5 clk = ~clk;
  always #5  cpu_s = ~cpu_s;
  always #15 pci_s = ~pci_s;
  always #5  sd_s  = ~sd_s;
  always #35 ref_s = ~ref_s;
  always #10 c48_s = ~c48_s;
  always #20 c24_s = ~c24_s;
  always #5  t_s   = ~t_s;

  clkgate_top u_clkgate_top (
    .rst_n(rst_n), .cpu_clk_in(cpu_s), .pci_clk_in(pci_s), .sdram_clk_in(sd_s),
    .ref_clk_in(ref_s), .clk48_in(c48_s), .clk24_in(c24_s), .test_clk_in(t_s),
    .mode_strap(mode_strap), .func_sel(func_sel), .cpu_en(cpu_en), .pci_en(pci_en),
    .pci_free_en(pci_free_en), .sdram_en(sdram_en), .ref_en(ref_en), .fx_en(fx_en),
    .fx_sel(fx_sel), .shared_in(shared_in), .cpu_out(cpu_out), .pci_out(pci_out),
    .pci_free_out(pci_free_out), .sdram_out(sdram_out), .shared_out(shared_out),
    .shared_oe(shared_oe), .ref_out(ref_out), .fx_out(fx_out), .drive_en(drive_en));

  function automatic logic [7:0] gexp(input logic [7:0] en, input logic run, input logic src);
    return en & {8{run & src}};
  endfunction

  function automatic logic [21:0] all_out();
    return {fx_out, ref_out, shared_out, sdram_out, pci_free_out, pci_out, cpu_out};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic set_defaults();
    mode_strap = 1; func_sel = 2'b00; cpu_en = '1; pci_en = '1; pci_free_en = 1;
    sdram_en = '1; ref_en = '1; fx_en = '1; fx_sel = '1; shared_in = '1;
  endtask

  task automatic count_rises(input int n);
    logic [21:0] prev, cur;
    foreach (rises[k]) rises[k] = 0;
    @(posedge clk); prev = all_out();
    for (int c = 0; c < n; c++) begin
      @(posedge clk); cur = all_out();
      for (int b = 0; b < 22; b++) if (cur[b] && !prev[b]) rises[b]++;
      prev = cur;
    end
  endtask

  // compare every output with the bench model over n samples
  task automatic compare_window(input int n);
    logic cpu_run, pci_run;
    logic [7:0] e;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      cpu_run = mode_strap | shared_in[1];
      pci_run = mode_strap | shared_in[0];
      check(mode_strap ? "R4" : "R2", "cpu_out", 32'(cpu_out), 32'(gexp(8'(cpu_en), cpu_run, cpu_s)));
      check("R3", "pci_out", 32'(pci_out), 32'(gexp(8'(pci_en), pci_run, pci_s)));
      check("R3", "pci_free_out", 32'(pci_free_out), 32'(pci_free_en & pci_s));
      check("R5", "sdram_out", 32'(sdram_out), 32'(gexp({2'b00, sdram_en[5:0]}, 1'b1, sd_s)));
      e = gexp(8'(sdram_en), mode_strap, sd_s);
      check("R1", "shared_out", 32'(shared_out), 32'({e[6], e[7]}));
      check("R1", "shared_oe", 32'(shared_oe), 32'({2{mode_strap}}));
      check("R5", "ref_out", 32'(ref_out), 32'(gexp(8'(ref_en), 1'b1, ref_s)));
      check("R6", "fx_out[0]", 32'(fx_out[0]), 32'(fx_en[0] & (fx_sel[0] ? c48_s : c24_s)));
      check("R6", "fx_out[1]", 32'(fx_out[1]), 32'(fx_en[1] & (fx_sel[1] ? c48_s : c24_s)));
      check("R5", "drive_en", 32'(drive_en), 32'd1);
    end
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int hi_len;
    logic armed;
    void'($urandom(32'd20240611));
    set_defaults();
    rst_n = 0;
    // R10: outputs low during reset
    for (int c = 0; c < 20; c++) begin
      @(posedge clk);
      check("R10", "outputs in reset", 32'(all_out()), 32'd0);
    end
    rst_n = 1;
    repeat (100) @(posedge clk);
    count_rises(128);
    for (int b = 0; b < 22; b++) check_range("R10", $sformatf("default toggling bit %0d", b), rises[b], 1, 1000);

    // directed: CPU stop and PCI stop with the strap low
    mode_strap = 0; shared_in = 2'b00;
    repeat (80) @(posedge clk);
    compare_window(24);
    shared_in = 2'b11;
    repeat (80) @(posedge clk);
    compare_window(24);

    // directed: strap high ignores low shared inputs
    mode_strap = 1; shared_in = 2'b00;
    repeat (80) @(posedge clk);
    compare_window(24);

    // random control patterns
    for (int it = 0; it < 30; it++) begin
      r = $urandom;
      mode_strap = r[0]; shared_in = r[2:1]; cpu_en = r[4:3]; pci_en = r[10:5];
      pci_free_en = r[11]; ref_en = r[14:12]; fx_en = r[16:15]; fx_sel = r[18:17];
      sdram_en = 8'($urandom);
      func_sel = r[19] ? 2'b10 : 2'b00;
      repeat (80) @(posedge clk);
      compare_window(24);
    end

    // R9: toggle PCI stop at random, measure completed high pulses
    set_defaults(); mode_strap = 0; shared_in = 2'b10;
    repeat (60) @(posedge clk);
    hi_len = 0; armed = 0;
    for (int c = 0; c < 800; c++) begin
      @(posedge clk);
      if (pci_out[0]) begin
        if (armed) hi_len++;
      end else begin
        if (armed && hi_len > 0) check("R9", "pci_out[0] high pulse length", 32'(hi_len), 32'd3);
        hi_len = 0; armed = 1;
      end
      if (($urandom % 7) == 0) shared_in[0] = ~shared_in[0];
    end
    shared_in = 2'b11;

    // R8: test clock substitution
    set_defaults(); func_sel = 2'b01; fx_sel = 2'b01;
    repeat (100) @(posedge clk);
    count_rises(128);
    for (int b = 0; b < 2; b++)   check_range("R8", "cpu div2", rises[b], 31, 33);
    for (int b = 2; b < 9; b++)   check_range("R8", "pci div4", rises[b], 15, 17);
    for (int b = 9; b < 17; b++)  check_range("R8", "sdram div2", rises[b], 31, 33);
    for (int b = 17; b < 20; b++) check_range("R8", "ref undivided", rises[b], 63, 65);
    check_range("R8", "fx0 48 div2", rises[20], 31, 33);
    check_range("R8", "fx1 24 div4", rises[21], 15, 17);

    // R7: quiet state
    set_defaults(); func_sel = 2'b11;
    repeat (100) @(posedge clk);
    for (int c = 0; c < 32; c++) begin
      @(posedge clk);
      check("R7", "outputs quiet", 32'(all_out()), 32'd0);
      check("R7", "drive_en", 32'(drive_en), 32'd0);
      check("R7", "shared_oe", 32'(shared_oe), 32'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule